// File: doc/BRIEF.md
# Calendar Clock with Deferred Register Commit

This block keeps wall-clock time and calendar date for a chip. Seconds, minutes and hours sit together in one packed 32-bit word. Day, month, a 6-bit year count from 1970 and a leap-year flag sit in a second word. Both words advance once per second. A step happens on each rising edge of a 1 Hz tick input. That input is a level sampled in the system clock domain. A small memory-mapped port lets software read either word and write new values.

A write does not take effect at once. The written word is held in a shadow register. It is applied on the second rising edge of the tick after the write. While the write waits, a per-word busy flag in a control word is set. Software polls that flag before it writes the same word again.

The port uses valid/ready. A read is never stalled. Its data comes back with `rd_valid` one cycle after the request is accepted, and it cannot be back-pressured. A write to a word whose earlier write has not yet been applied is held off: `bus_ready` stays low until the commit. A write to the other word is accepted meanwhile.

Top module: `cal_clock`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00000101 (day 1, month 1, year count 0, leap flag 0) and the control word reads 0. `bus_ready` is high and `rd_valid` is low.
- R2: The time word is at offset 0x14. It holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16; all other bits read zero. Read data appears on `rd_data` with `rd_valid` high in the cycle after the read is accepted.
- R3: The date word is at offset 0x10. It holds day in bits 4:0, month in bits 11:8, year count from 1970 in bits 21:16 and the leap flag in bit 22; all other bits read zero.
- R4: The control word is at offset 0x00. Bit 8 is set while a time write waits and bit 7 while a date write waits; every other bit reads zero. Writes to the control word change nothing. Reads of any other offset return zero.
- R5: An accepted write leaves the running word unchanged, and the word keeps counting, until the second tick rising edge that falls after the write. At that edge the write is applied and the busy bit clears.
- R6: A write stores only the field bits of the written data. At the commit edge the stored word replaces the running word whole. No counting step and no carry from the time word applies to that word at that edge.
- R7: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry one day into the date.
- R8: Months 4, 6, 9 and 11 wrap the day after 30. All other months except February wrap after 31. The day then goes to 1 and the month steps.
- R9: February wraps after day 29 when the stored leap flag is 1, and after day 28 when it is 0.
- R10: After day 31 of month 12 the date becomes day 1, month 1, with the year count plus one (63 wraps to 0). The leap flag is set exactly when 1970 plus the new count is divisible by 4.
- R11: A read is always accepted. A write to a word whose busy bit is set sees `bus_ready` low until that commit.
- R12: A tick held high for many cycles advances the calendar only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | Once-per-second tick level; each rising edge is one step |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted when high together with `bus_valid` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 32 | Read data |

## Verification
The bench targets the commit timing. A design that applied a write on the first tick edge, or at once, would return the new time one tick early. A design that froze the running word while a write waited would return zero instead of the counted value. At the commit edge it checks that the written word replaces the counted one, and that a pending date write swallows the midnight carry. A wrong priority would show up as an extra second or a day late. The calendar edges are 30/31-day months, February with and without the leap flag, New Year with leap recomputation, and the year count wrapping from 63 to 0. Any wrong month-length table or leap rule puts the date one day off. Back-pressure on a second write to a busy word, a tick held high, and writes to the control word round it out. These would show as an accepted write, multiple steps, or corrupted state.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int DATA_W   = 32;
  localparam int SEC_LAST = 59;
  localparam int MIN_LAST = 59;
  localparam int HR_LAST  = 23;
  localparam int MON_LAST = 12;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } tod_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] yr;
    logic [3:0] mon;
    logic [4:0] day;
  } ymd_t;

  function automatic logic [DATA_W-1:0] tod_to_word(tod_t t);
    return {11'd0, t.hr, 2'd0, t.mn, 2'd0, t.sc};
  endfunction

  function automatic tod_t word_to_tod(logic [DATA_W-1:0] w);
    tod_t t;
    t.hr = w[20:16];
    t.mn = w[13:8];
    t.sc = w[5:0];
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] ymd_to_word(ymd_t d);
    return {9'd0, d.leap, d.yr, 4'd0, d.mon, 3'd0, d.day};
  endfunction

  function automatic ymd_t word_to_ymd(logic [DATA_W-1:0] w);
    ymd_t d;
    d.leap = w[22];
    d.yr   = w[21:16];
    d.mon  = w[11:8];
    d.day  = w[4:0];
    return d;
  endfunction

  function automatic logic [4:0] month_len(logic [3:0] mon, logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_tick_edge.sv
module cal_tick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic rise
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_in;
  end

  assign rise = tick_in && !tick_q;
endmodule

// File: rtl/cal_commit_track.sv
module cal_commit_track #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic rise,
  output logic busy,
  output logic commit
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign commit = busy && rise && !arm && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (arm) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (commit) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && rise) begin
      cnt  <= cnt + CW'(1);
    end
  end

  // R5
  busy_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rise));
endmodule

// File: rtl/cal_tod_counter.sv
module cal_tod_counter
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load,
  input  tod_t load_val,
  output tod_t tod_q,
  output logic day_carry
);
  logic sec_wrap, min_wrap, hr_wrap;
  tod_t nxt;

  assign sec_wrap  = tod_q.sc >= 6'(SEC_LAST);
  assign min_wrap  = tod_q.mn >= 6'(MIN_LAST);
  assign hr_wrap   = tod_q.hr >= 5'(HR_LAST);
  assign day_carry = step && !load && sec_wrap && min_wrap && hr_wrap;

  always_comb begin
    nxt = tod_q;
    if (!sec_wrap) begin
      nxt.sc = tod_q.sc + 6'd1;
    end else begin
      nxt.sc = '0;
      if (!min_wrap) begin
        nxt.mn = tod_q.mn + 6'd1;
      end else begin
        nxt.mn = '0;
        nxt.hr = hr_wrap ? 5'd0 : tod_q.hr + 5'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    tod_q <= '0;
    else if (load) tod_q <= load_val;
    else if (step) tod_q <= nxt;
  end

  // R12
  tod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(step) && !$past(load)) |-> $stable(tod_q));
endmodule

// File: rtl/cal_ymd_counter.sv
module cal_ymd_counter
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load,
  input  ymd_t load_val,
  output ymd_t ymd_q
);
  localparam ymd_t RESET_VAL = '{leap: 1'b0, yr: 6'd0, mon: 4'd1, day: 5'd1};

  logic [4:0] mlen;
  logic [5:0] yr_inc;
  ymd_t       nxt;

  assign mlen   = month_len(ymd_q.mon, ymd_q.leap);
  assign yr_inc = ymd_q.yr + 6'd1;

  always_comb begin
    nxt = ymd_q;
    if (ymd_q.day < mlen) begin
      nxt.day = ymd_q.day + 5'd1;
    end else begin
      nxt.day = 5'd1;
      if (ymd_q.mon < 4'(MON_LAST)) begin
        nxt.mon = ymd_q.mon + 4'd1;
      end else begin
        nxt.mon  = 4'd1;
        nxt.yr   = yr_inc;
        // 1970 is 2 mod 4, so a count of 2 mod 4 is a leap year
        nxt.leap = (yr_inc[1:0] == 2'd2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ymd_q <= RESET_VAL;
    else if (load) ymd_q <= load_val;
    else if (step) ymd_q <= nxt;
  end

  // R7
  ymd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step && !load) |-> (ymd_q != $past(ymd_q)));

  // R10
  new_year_leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step && !load) && ymd_q.mon == 4'd1 && ymd_q.day == 5'd1)
      |-> (ymd_q.leap == (ymd_q.yr[1:0] == 2'd2)));
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int              ADDR_W       = 8,
  parameter int              COMMIT_TICKS = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFF   = ADDR_W'(8'h00),
  parameter logic [ADDR_W-1:0] DATE_OFF   = ADDR_W'(8'h10),
  parameter logic [ADDR_W-1:0] TIME_OFF   = ADDR_W'(8'h14),
  parameter int              BUSY_LSB     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  localparam int NREG   = 2;
  localparam int IDX_DT = 0;
  localparam int IDX_TM = 1;

  logic            rise;
  logic            sel_ctrl, sel_date, sel_time;
  logic [NREG-1:0] sel, arm, busy, commit;
  logic            accept, blocked;
  tod_t            tod_q, tod_shadow;
  ymd_t            ymd_q, ymd_shadow;
  logic            day_carry;
  logic [31:0]     ctrl_word, rd_mux;

  cal_tick_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_in(tick_1hz),
    .rise   (rise)
  );

  assign sel_ctrl     = (bus_addr == CTRL_OFF);
  assign sel_date     = (bus_addr == DATE_OFF);
  assign sel_time     = (bus_addr == TIME_OFF);
  assign sel[IDX_DT]  = sel_date;
  assign sel[IDX_TM]  = sel_time;

  assign blocked   = bus_write && |(sel & busy);
  assign bus_ready = !blocked;
  assign accept    = bus_valid && bus_ready;

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_track
      assign arm[gi] = accept && bus_write && sel[gi];
      cal_commit_track #(.TICKS(COMMIT_TICKS)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm[gi]),
        .rise  (rise),
        .busy  (busy[gi]),
        .commit(commit[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_shadow <= '0;
      ymd_shadow <= '0;
    end else begin
      if (arm[IDX_TM]) tod_shadow <= word_to_tod(bus_wdata);
      if (arm[IDX_DT]) ymd_shadow <= word_to_ymd(bus_wdata);
    end
  end

  cal_tod_counter u_tod (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (rise),
    .load     (commit[IDX_TM]),
    .load_val (tod_shadow),
    .tod_q    (tod_q),
    .day_carry(day_carry)
  );

  cal_ymd_counter u_ymd (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (day_carry),
    .load    (commit[IDX_DT]),
    .load_val(ymd_shadow),
    .ymd_q   (ymd_q)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BUSY_LSB + IDX_DT] = busy[IDX_DT];
    ctrl_word[BUSY_LSB + IDX_TM] = busy[IDX_TM];
  end

  always_comb begin
    if (sel_time)      rd_mux = tod_to_word(tod_q);
    else if (sel_date) rd_mux = ymd_to_word(ymd_q);
    else if (sel_ctrl) rd_mux = ctrl_word;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept && !bus_write;
      if (accept && !bus_write) rd_data <= rd_mux;
    end
  end

  // R11
  read_never_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |-> bus_ready);

  // R2
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && bus_ready && !bus_write));
endmodule

// File: tb/cal_clock_bench.sv
module cal_clock_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DATE = 8'h10;
  localparam logic [7:0] A_TIME = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rd_valid;
  logic [31:0] rd_data;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t expq[$];
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_clock u_cal_clock (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick),
    .bus_valid(bus_valid),
    .bus_ready(bus_ready),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    exp_t x;
    if (rst_n && rd_valid) begin
      n_cmp++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected read data %h, expected none", rd_data);
      end else begin
        x = expq.pop_front();
        if (rd_data !== x.val) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", x.tag, rd_data, x.val);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    expq.push_back('{e, tag});
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic tick_pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_both(input logic [31:0] d, input logic [31:0] t);
    wr(A_DATE, d);
    wr(A_TIME, t);
    tick_pulse();
    tick_pulse();
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'd0, bus_ready}, 32'd1, "R1 ready after reset");
    chk({31'd0, rd_valid}, 32'd0, "R1 rd_valid after reset");
    rd(A_CTRL, 32'h0, "R1 ctrl reset");
    rd(A_TIME, 32'h0, "R1 time reset");
    rd(A_DATE, 32'h0000_0101, "R1 R3 date reset");

    // deferred time write with junk outside the fields
    wr(A_TIME, 32'hC0F7_FBFA);
    rd(A_CTRL, 32'h0000_0100, "R5 time busy set");
    rd(A_TIME, 32'h0, "R5 time not yet applied");
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_TIME; bus_wdata = '0;
    #1 chk({31'd0, bus_ready}, 32'd0, "R11 second time write held off");
    bus_write = 1'b0;
    #1 chk({31'd0, bus_ready}, 32'd1, "R11 read accepted while busy");
    bus_valid = 1'b0;
    tick_pulse();
    rd(A_TIME, 32'h0000_0001, "R5 counting during pending write");
    rd(A_CTRL, 32'h0000_0100, "R5 busy after first tick");
    tick_pulse();
    rd(A_TIME, 32'h0017_3B3A, "R6 R2 masked word applied on second tick");
    rd(A_CTRL, 32'h0, "R5 busy cleared after commit");

    // date commit swallows the midnight carry
    wr(A_DATE, 32'h0005_0C1F);
    tick_pulse();
    tick_pulse();
    rd(A_TIME, 32'h0, "R6 time wrapped at date commit");
    rd(A_DATE, 32'h0005_0C1F, "R6 date commit wins over carry");

    // new year, leap recomputed (1976)
    set_both(32'h0005_0C1F, 32'h0017_3B3B);
    tick_pulse();
    rd(A_TIME, 32'h0, "R7 midnight wrap");
    rd(A_DATE, 32'h0046_0101, "R10 new year sets leap");

    // leap February, both words pending together
    wr(A_DATE, 32'h0046_021C);
    wr(A_TIME, 32'h0017_3B3B);
    rd(A_CTRL, 32'h0000_0180, "R4 both busy bits");
    tick_pulse();
    tick_pulse();
    tick_pulse();
    rd(A_DATE, 32'h0046_021D, "R9 leap Feb 29");
    set_both(32'h0046_021D, 32'h0017_3B3B);
    tick_pulse();
    rd(A_DATE, 32'h0046_0301, "R9 leap Feb 29 to Mar 1");
    set_both(32'h0005_021C, 32'h0017_3B3B);
    tick_pulse();
    rd(A_DATE, 32'h0005_0301, "R9 non-leap Feb 28 to Mar 1");

    // month lengths
    set_both(32'h0005_041E, 32'h0017_3B3B);
    tick_pulse();
    rd(A_DATE, 32'h0005_0501, "R8 April 30 to May 1");
    set_both(32'h0005_011E, 32'h0017_3B3B);
    tick_pulse();
    rd(A_DATE, 32'h0005_011F, "R8 January reaches 31");

    // year count wrap
    set_both(32'h003F_0C1F, 32'h0017_3B3B);
    tick_pulse();
    rd(A_DATE, 32'h0000_0101, "R10 year 63 wraps to 0");

    // minute and hour carries
    set_both(32'h0000_0101, 32'h0000_3B3B);
    tick_pulse();
    rd(A_TIME, 32'h0001_0000, "R7 hour carry");
    rd(A_DATE, 32'h0000_0101, "R7 no day carry before midnight");
    set_both(32'h0000_0101, 32'h0000_0A3B);
    tick_pulse();
    rd(A_TIME, 32'h0000_0B00, "R7 minute carry");

    // held tick
    @(negedge clk); tick = 1'b1;
    repeat (6) @(negedge clk);
    tick = 1'b0;
    rd(A_TIME, 32'h0000_0B01, "R12 held tick steps once");

    // control writes ignored, unmapped offsets read zero
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, 32'h0, "R4 control write ignored");
    rd(A_TIME, 32'h0000_0B01, "R4 time untouched by control write");
    rd(A_DATE, 32'h0000_0101, "R3 R4 date untouched by control write");
    rd(8'h20, 32'h0, "R4 unmapped offset reads zero");
    rd(8'h18, 32'h0, "R4 unmapped offset 0x18 reads zero");

    repeat (3) @(negedge clk);
    chk(32'(expq.size()), 32'd0, "R2 all reads answered");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule